// File: doc/BRIEF.md
# Display List Program Counter Controller

This block owns the instruction address of a display list coprocessor. Software keeps two 32-bit list locations, each loaded as two 16-bit halves through a narrow register port. The active program counter is separate from those locations. It is redirected only when software writes one of two jump strobe selects, or when the vertical blank pulse arrives. Each location update is therefore held back until a well-defined moment, and a list already in progress runs on undisturbed.

While DMA is enabled, the block requests 16-bit words at the program counter. It steps the counter by two on every acknowledged word. It joins each two consecutive words into one 32-bit instruction, which it presents for a single cycle. Turning DMA off stops the requests and freezes the counter and any half-built instruction. Fetching resumes from the same place later.

A reload discards any word acknowledged in the same cycle, along with a half-built instruction. The coprocessor therefore always begins the new list on an instruction boundary.

Top module: `dlpc_top`

## Requirements
- R1: After reset both locations and the program counter are zero, `fetch_addr` is 0, `fetch_req` is low while `dma_en` is low, and `instr_valid` is low.
- R2: Register select codes are: 0 = location 1 upper half, 1 = location 1 lower half, 2 = location 2 upper half, 3 = location 2 lower half. A lower-half write stores the data with bit 0 forced to 0.
- R3: Writing a location register leaves the program counter (`fetch_addr`) unchanged.
- R4: A write of any data with select 4 loads the program counter from location 1, and a write with select 5 loads it from location 2. The new value is visible on `fetch_addr` after the writing clock edge.
- R5: A `vblank` pulse loads the program counter from location 1.
- R6: When a jump strobe write and `vblank` occur in the same cycle, the strobe's location wins.
- R7: While `dma_en` is low, `fetch_req` is low and the program counter holds. On re-enable, fetching resumes from the retained counter even if a location was rewritten meanwhile.
- R8: A jump strobe written while `dma_en` is low still reloads the program counter.
- R9: When two jump strobes are written a few cycles apart, the later one determines the program counter.
- R10: Each cycle with `fetch_req` and `fetch_ack` both high advances the counter by 2. Every second accepted word completes an instruction: `instr_word` = {first word, second word}, with `instr_valid` high for exactly one cycle.
- R11: A word acknowledged in a reload cycle is dropped, and any half-built instruction is cleared. The first instruction after a reload is made of the two words at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register port write strobe |
| reg_sel | input | 3 | Register select (see R2, R4) |
| reg_wdata | input | 16 | Register write data |
| vblank | input | 1 | One-cycle vertical blank pulse |
| dma_en | input | 1 | Enables word fetching |
| fetch_req | output | 1 | Word fetch request |
| fetch_addr | output | 32 | Fetch address (the program counter) |
| fetch_ack | input | 1 | Fetch acknowledge; data valid this cycle |
| fetch_data | input | 16 | Fetched word |
| instr_valid | output | 1 | One-cycle pulse marking a completed instruction |
| instr_word | output | 32 | Completed two-word instruction |

## Verification
Some properties are checked on every cycle inside the RTL:
- the counter steps by 2 per accepted word, holds while DMA is off, and lands exactly on the reload address;
- the strobe wins over vertical blank;
- the instruction pulse is a single cycle and is never raised right after a reload;
- a location changes only when its own half is written.

Other behaviours depend on history across many cycles, so only the bench scenarios can show them. These are resuming from the retained counter after the locations change, the later of two strobes deciding the counter, and a half-built instruction being thrown away at a reload. The bench shows them by comparing every emitted instruction with words predicted from the expected address sequence.

// File: rtl/dlpc_pkg.sv
package dlpc_pkg;
  localparam int SEL_W = 3;
  typedef enum logic [SEL_W-1:0] {
    SEL_L1_HI = 3'd0,
    SEL_L1_LO = 3'd1,
    SEL_L2_HI = 3'd2,
    SEL_L2_LO = 3'd3,
    SEL_JMP1  = 3'd4,
    SEL_JMP2  = 3'd5
  } reg_sel_e;
  localparam int JMP_BASE = 4;
endpackage

// File: rtl/dlpc_loc_regs.sv
module dlpc_loc_regs
  import dlpc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int HALF_W  = 16,
  parameter int NUM_LOC = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [SEL_W-1:0]                wr_sel,
  input  logic [HALF_W-1:0]               wr_data,
  output logic [NUM_LOC-1:0][ADDR_W-1:0]  loc
);
  logic [NUM_LOC-1:0][ADDR_W-1:0] loc_q;
  logic [NUM_LOC-1:0][ADDR_W-1:0] loc_n;
  logic [NUM_LOC-1:0]             loc_en;

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
    localparam logic [SEL_W-1:0] HI_SEL = SEL_W'(2 * g);
    localparam logic [SEL_W-1:0] LO_SEL = SEL_W'(2 * g + 1);
    logic hi_wr, lo_wr;

    always_comb begin
      hi_wr     = wr_en && (wr_sel == HI_SEL);
      lo_wr     = wr_en && (wr_sel == LO_SEL);
      loc_en[g] = hi_wr || lo_wr;
      loc_n[g]  = loc_q[g];
      if (hi_wr) loc_n[g][ADDR_W-1:HALF_W] = wr_data;
      if (lo_wr) loc_n[g][HALF_W-1:0]      = {wr_data[HALF_W-1:1], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         loc_q[g] <= '0;
      else if (loc_en[g]) loc_q[g] <= loc_n[g];
    end

    // R2: a location moves only when one of its own halves is written
    p_loc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_sel == HI_SEL || wr_sel == LO_SEL)) |=> $stable(loc_q[g]));
  end

  assign loc = loc_q;
endmodule

// File: rtl/dlpc_reload.sv
module dlpc_reload
  import dlpc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_LOC = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [SEL_W-1:0]               wr_sel,
  input  logic                           vblank,
  input  logic [NUM_LOC-1:0][ADDR_W-1:0] loc,
  output logic                           reload,
  output logic [ADDR_W-1:0]              reload_addr
);
  logic [NUM_LOC-1:0] strobe;

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_strobe
    assign strobe[g] = wr_en && (wr_sel == SEL_W'(JMP_BASE + g));
  end

  // Strobe beats vertical blank; vertical blank always targets location 1.
  always_comb begin
    reload      = vblank;
    reload_addr = loc[0];
    for (int i = 0; i < NUM_LOC; i++) begin
      if (strobe[i]) begin
        reload      = 1'b1;
        reload_addr = loc[i];
      end
    end
  end

  // R6: strobe to location 2 together with vertical blank uses location 2
  p_strobe_over_vblank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && wr_en && wr_sel == SEL_JMP2) |-> (reload_addr == loc[NUM_LOC-1]));
  // R5: a lone vertical blank requests a reload
  p_vblank_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |-> reload);
endmodule

// File: rtl/dlpc_fetch.sv
module dlpc_fetch #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dma_en,
  input  logic                reload,
  input  logic [ADDR_W-1:0]   reload_addr,
  input  logic                fetch_ack,
  input  logic [WORD_W-1:0]   fetch_data,
  output logic                fetch_req,
  output logic [ADDR_W-1:0]   fetch_addr,
  output logic                instr_valid,
  output logic [2*WORD_W-1:0] instr_word
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

  logic [ADDR_W-1:0]   pc_q, pc_n;
  logic                half_q, half_n;
  logic [WORD_W-1:0]   hold_q;
  logic [2*WORD_W-1:0] word_q;
  logic                valid_q, valid_n;
  logic                take, pc_en, hold_en, word_en;

  assign fetch_req = dma_en;

  always_comb begin
    take    = fetch_req && fetch_ack && !reload;
    pc_en   = reload || take;
    pc_n    = reload ? reload_addr : pc_q + STEP;
    half_n  = half_q;
    hold_en = 1'b0;
    word_en = 1'b0;
    valid_n = 1'b0;
    if (reload) begin
      half_n = 1'b0;
    end else if (take) begin
      half_n  = !half_q;
      hold_en = !half_q;
      word_en = half_q;
      valid_n = half_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      half_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_n;
      half_q  <= half_n;
      if (pc_en) pc_q <= pc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      word_q <= '0;
    end else begin
      if (hold_en) hold_q <= fetch_data;
      if (word_en) word_q <= {hold_q, fetch_data};
    end
  end

  assign fetch_addr  = pc_q;
  assign instr_valid = valid_q;
  assign instr_word  = word_q;

  // R10: every accepted word advances the address by one word
  p_pc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ack && !reload) |=> (fetch_addr == $past(fetch_addr) + STEP));
  // R7: no fetching and no movement while DMA is off
  p_pc_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && !reload) |=> $stable(fetch_addr));
  // R4: a reload lands exactly on the selected location
  p_reload_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (fetch_addr == $past(reload_addr)));
  // R10: instruction pulse lasts one cycle
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> !instr_valid);
  // R11: a reload never completes an instruction
  p_reload_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !instr_valid);
endmodule

// File: rtl/dlpc_top.sv
module dlpc_top
  import dlpc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 16,
  parameter int NUM_LOC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [SEL_W-1:0]    reg_sel,
  input  logic [WORD_W-1:0]   reg_wdata,
  input  logic                vblank,
  input  logic                dma_en,
  output logic                fetch_req,
  output logic [ADDR_W-1:0]   fetch_addr,
  input  logic                fetch_ack,
  input  logic [WORD_W-1:0]   fetch_data,
  output logic                instr_valid,
  output logic [2*WORD_W-1:0] instr_word
);
  logic [NUM_LOC-1:0][ADDR_W-1:0] loc;
  logic                           reload;
  logic [ADDR_W-1:0]              reload_addr;

  dlpc_loc_regs #(.ADDR_W(ADDR_W), .HALF_W(WORD_W), .NUM_LOC(NUM_LOC)) u_loc (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_sel(reg_sel),
    .wr_data(reg_wdata), .loc(loc)
  );

  dlpc_reload #(.ADDR_W(ADDR_W), .NUM_LOC(NUM_LOC)) u_reload (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_sel(reg_sel),
    .vblank(vblank), .loc(loc), .reload(reload), .reload_addr(reload_addr)
  );

  dlpc_fetch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .reload(reload),
    .reload_addr(reload_addr), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .instr_valid(instr_valid), .instr_word(instr_word)
  );
endmodule

// File: tb/dlpc_top_tb.sv
module dlpc_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_sel;
  logic [15:0] reg_wdata;
  logic        vblank, dma_en, ack_en;
  logic        fetch_req, fetch_ack, instr_valid;
  logic [31:0] fetch_addr, instr_word;
  logic [15:0] fetch_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit prev_valid = 1'b0;
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [31:0] a);
    return a[16:1] ^ 16'h3C5A;
  endfunction

  assign fetch_ack  = ack_en;
  assign fetch_data = mem_word(fetch_addr);

  dlpc_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .vblank(vblank), .dma_en(dma_en),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
    .fetch_data(fetch_data), .instr_valid(instr_valid), .instr_word(instr_word)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push_pairs(input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++)
      exp_q.push_back({mem_word(base + 32'(4*i)), mem_word(base + 32'(4*i + 2))});
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // Scoreboard monitor: every instruction pulse is matched against the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (instr_valid) begin
        check(!prev_valid, "R10 pulse width", 32'(prev_valid), 32'd0);
        if (exp_q.size() == 0) check(1'b0, "R11 unexpected instruction", instr_word, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(instr_word == e, "R10 instruction word", instr_word, e);
        end
      end
      prev_valid = instr_valid;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    vblank = 1'b0; dma_en = 1'b0; ack_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(fetch_addr == 32'h0, "R1 pc", fetch_addr, 32'h0);
    check(!fetch_req, "R1 req", 32'(fetch_req), 32'h0);
    check(!instr_valid, "R1 valid", 32'(instr_valid), 32'h0);

    // R2 halves with bit 0 forced; R8/R4 strobe 1 while DMA off
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'h1001);
    check(fetch_addr == 32'h0, "R3 pc after loc write", fetch_addr, 32'h0);
    wr(3'd4, 16'hBEEF);
    check(fetch_addr == 32'h0001_1000, "R2 R4 R8 strobe1", fetch_addr, 32'h0001_1000);
    check(!fetch_req, "R7 no req when off", 32'(fetch_req), 32'h0);

    // R10 continuous fetch, three instructions
    push_pairs(32'h0001_1000, 3);
    dma_en = 1'b1; ack_en = 1'b1;
    repeat (6) @(negedge clk);
    dma_en = 1'b0; ack_en = 1'b0;
    check(fetch_addr == 32'h0001_100C, "R10 pc step", fetch_addr, 32'h0001_100C);
    @(negedge clk);
    check(exp_q.size() == 0, "R10 all pairs seen", 32'(exp_q.size()), 32'h0);

    // R3 location rewrite does not move pc; R7 resume from retained pc
    wr(3'd0, 16'h0002);
    wr(3'd1, 16'h0000);
    check(fetch_addr == 32'h0001_100C, "R3 pc held", fetch_addr, 32'h0001_100C);
    push_pairs(32'h0001_100C, 2);
    dma_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      ack_en = ~i[0];
      @(negedge clk);
    end
    dma_en = 1'b0; ack_en = 1'b0;
    check(fetch_addr == 32'h0001_1014, "R7 resume", fetch_addr, 32'h0001_1014);
    @(negedge clk);
    check(exp_q.size() == 0, "R7 pairs seen", 32'(exp_q.size()), 32'h0);

    // R5 vertical blank reload from location 1
    vblank = 1'b1;
    @(negedge clk);
    vblank = 1'b0;
    check(fetch_addr == 32'h0002_0000, "R5 vblank", fetch_addr, 32'h0002_0000);

    // R6 strobe 2 and vblank in the same cycle
    wr(3'd2, 16'h0003);
    wr(3'd3, 16'h0040);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd5; reg_wdata = 16'h0000; vblank = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; vblank = 1'b0;
    check(fetch_addr == 32'h0003_0040, "R6 R4 strobe2 wins", fetch_addr, 32'h0003_0040);

    // R9 later strobe decides
    wr(3'd4, 16'h1111);
    @(negedge clk);
    wr(3'd5, 16'h2222);
    check(fetch_addr == 32'h0003_0040, "R9 last is strobe2", fetch_addr, 32'h0003_0040);
    wr(3'd5, 16'h3333);
    @(negedge clk);
    wr(3'd4, 16'h4444);
    check(fetch_addr == 32'h0002_0000, "R9 last is strobe1", fetch_addr, 32'h0002_0000);

    // R11 reload during fetch drops in-flight word and partial pair
    push_pairs(32'h0003_0040, 2);
    dma_en = 1'b1; ack_en = 1'b1;
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd5; reg_wdata = 16'h5555;
    @(negedge clk);
    reg_we = 1'b0;
    check(fetch_addr == 32'h0003_0040, "R11 reload drops ack", fetch_addr, 32'h0003_0040);
    repeat (4) @(negedge clk);
    dma_en = 1'b0; ack_en = 1'b0;
    check(fetch_addr == 32'h0003_0048, "R11 pc after reload", fetch_addr, 32'h0003_0048);
    @(negedge clk);
    check(exp_q.size() == 0, "R11 pairs seen", 32'(exp_q.size()), 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule